// File: doc/BRIEF.md
# Grouped Prescaler Tick Generator

This block turns one fixed 24 MHz reference clock into five independent count-enable strobes, one per timer channel. Channels 0 and 1 share an 8-bit prescaler and channels 2, 3 and 4 share a second one. Each channel then thins its group's strobe stream by its own power-of-two factor, chosen by a 4-bit field. The counters that consume the strobes sit outside this block.

Two 32-bit configuration words arrive through a simple write port. Any write restarts every prescaler and divider. Each channel therefore resumes from a clean phase and emits its first strobe after exactly one full period of the new setting. No strobe left over from the old setting can follow the write.

Top module: `tick_gen_top`

## Requirements
- R1: While rst_ni is low, tick_o is all zero. After release, word 0 holds 0x0101 and word 1 holds 0, so every channel pulses on the 3rd clock edge after release and then every 2 cycles.
- R2: Channel n pulses once every N = (P+1)*D reference cycles, where P is the channel's prescale byte and D its divide factor.
- R3: Channels 0 and 1 take P from bits [7:0] of word 0, and those bits affect no other channel.
- R4: Channels 2, 3 and 4 take P from bits [15:8] of word 0. Bits [31:16] of word 0 have no effect.
- R5: Channel n takes a field value v from bits [4n+3:4n] of word 1 and divides by D = 2^v for v from 0 to 4. Bits [31:20] of word 1 have no effect.
- R6: A field value v from 5 to 15 gives D = 16.
- R7: A word is written when cfg_wr_i is high at a rising edge. cfg_sel_i = 0 selects word 0 and cfg_sel_i = 1 selects word 1. The other word keeps its value.
- R8: When a write is sampled at edge E, no channel pulses on edges E+1 through E+N. Each channel then pulses on edge E+N+1 and every N cycles after that, with N taken from the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Word select: 0 = prescale word, 1 = divider word |
| cfg_data_i | input | 32 | Write data |
| tick_o | output | 5 | Per-channel count-enable pulses |

## Verification
The assertions assume that reset is asserted before the first edge. They also assume that cfg_sel_i and cfg_data_i are valid whenever cfg_wr_i is high. A configuration change only moves the prescale bound after the restart cycle that follows it. The bench issues every write as a single-cycle strobe at a falling edge and then watches the outputs for at least two full periods before the next write, so each sampled window reflects exactly one configuration.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic {
    CFG_PRE = 1'b0,
    CFG_DIV = 1'b1
  } cfg_sel_e;

  localparam int unsigned CFG_W      = 32;
  localparam logic [31:0] PRE_RST    = 32'h0000_0101;
  localparam logic [31:0] DIV_RST    = 32'h0000_0000;
endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs
  import tick_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  cfg_sel_e         sel_i,
  input  logic [CFG_W-1:0] data_i,
  output logic [CFG_W-1:0] pre_word_o,
  output logic [CFG_W-1:0] div_word_o,
  output logic             restart_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_word_o <= PRE_RST;
      div_word_o <= DIV_RST;
      restart_o  <= 1'b1;   // first cycle after reset aligns all counters
    end else begin
      restart_o <= wr_i;
      if (wr_i && sel_i == CFG_PRE) pre_word_o <= data_i;
      if (wr_i && sel_i == CFG_DIV) div_word_o <= data_i;
    end
  end

  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(pre_word_o) && $stable(div_word_o)));
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] load_i,
  output logic             stb_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restart_i || cnt_q == '0) cnt_q <= load_i;
    else                             cnt_q <= cnt_q - 1'b1;
  end

  assign stb_o = (cnt_q == '0) && !restart_i;

  assert_pre_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || restart_i)
    cnt_q <= load_i);
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned MAX_LOG = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             stb_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned CW = (MAX_LOG > 0) ? MAX_LOG : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mask;
  logic [SEL_W-1:0] eff;

  always_comb begin
    eff = (sel_i > SEL_W'(MAX_LOG)) ? SEL_W'(MAX_LOG) : sel_i;
    for (int b = 0; b < CW; b++) mask[b] = (SEL_W'(b) < eff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      if (stb_i) cnt_q <= cnt_q + 1'b1;
      tick_o <= stb_i && ((cnt_q & mask) == mask);
    end
  end

  assert_div1_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && sel_i == '0 && !restart_i) |=> tick_o);
endmodule

// File: rtl/tick_gen_top.sv
module tick_gen_top
  import tick_pkg::*;
#(
  parameter int unsigned NUM_CH  = 5,
  parameter int unsigned GRP0_CH = 2,
  parameter int unsigned PRE_W   = 8,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned MAX_LOG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic              cfg_sel_i,
  input  logic [31:0]       cfg_data_i,
  output logic [NUM_CH-1:0] tick_o
);
  localparam int unsigned NUM_GRP = 2;

  logic [CFG_W-1:0]   pre_word, div_word;
  logic               restart;
  logic [NUM_GRP-1:0] grp_stb;

  tick_cfg_regs u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cfg_wr_i),
    .sel_i      (cfg_sel_e'(cfg_sel_i)),
    .data_i     (cfg_data_i),
    .pre_word_o (pre_word),
    .div_word_o (div_word),
    .restart_o  (restart)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
    tick_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .load_i    (pre_word[g*PRE_W +: PRE_W]),
      .stb_o     (grp_stb[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned GRP = (c < GRP0_CH) ? 0 : 1;
    tick_divider #(.SEL_W(SEL_W), .MAX_LOG(MAX_LOG)) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .stb_i     (grp_stb[GRP]),
      .sel_i     (div_word[c*SEL_W +: SEL_W]),
      .tick_o    (tick_o[c])
    );

    assert_tick_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o[c] |-> $past(grp_stb[GRP]));
  end

  assert_restart_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (tick_o == '0));
endmodule

// File: tb/sim_tick_gen_top.sv
module sim_tick_gen_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic        cfg_sel_i = 1'b0;
  logic [31:0] cfg_data_i = '0;
  logic [4:0]  tick_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] w0 = 32'h0000_0101;
  logic [31:0] w1 = 32'h0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  tick_gen_top u0 (.*);

  function automatic int exp_n(int ch, logic [31:0] a, logic [31:0] b);
    int p, v, d;
    p = (ch < 2) ? int'(a[7:0]) : int'(a[15:8]);
    v = int'((b >> (4*ch)) & 32'hF);
    d = (v > 4) ? 16 : (1 << v);
    return (p + 1) * d;
  endfunction

  function automatic bit exp_tick(int j, int n);
    return (j >= n + 1) && (((j - 1) % n) == 0);
  endfunction

  // observe W edges after the restart point; one check per channel
  task automatic observe(string tag);
    int n[5];
    int bad[5];
    int got_j[5];
    int w;
    w = 0;
    for (int c = 0; c < 5; c++) begin
      n[c] = exp_n(c, w0, w1);
      bad[c] = 0;
      got_j[c] = -1;
      if (2*n[c] + 2 > w) w = 2*n[c] + 2;
    end
    for (int j = 1; j <= w; j++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      for (int c = 0; c < 5; c++)
        if (tick_o[c] !== exp_tick(j, n[c]) && bad[c] == 0) begin
          bad[c] = 1;
          got_j[c] = j;
        end
    end
    for (int c = 0; c < 5; c++) begin
      n_tests++;
      if (bad[c] != 0) begin
        n_fail++;
        $display("FAIL %s ch%0d: mismatch at edge %0d, actual tick=%0b expected period %0d (w0=%h w1=%h)",
                 tag, c, got_j[c], !exp_tick(got_j[c], n[c]), n[c], w0, w1);
      end
    end
  endtask

  task automatic cfg_write(bit sel, logic [31:0] d);
    @(negedge clk_i);
    cfg_wr_i = 1'b1;
    cfg_sel_i = sel;
    cfg_data_i = d;
    if (sel) w1 = d; else w0 = d;
    @(posedge clk_i);
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
    cfg_data_i = $urandom;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk_i);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    repeat (3) @(negedge clk_i);
    n_tests++;
    if (tick_o !== 5'b0) begin
      n_fail++;
      $display("FAIL R1 reset: actual %b expected 00000", tick_o);
    end
    rst_ni = 1'b1;
    observe("R1");

    // R3: change only prescaler 0
    idle(3);
    cfg_write(1'b0, 32'h0000_0104);
    observe("R3");

    // R4: prescaler 1 with junk upper bits
    idle(5);
    cfg_write(1'b0, 32'hA5C3_0502);
    observe("R4");

    // R5: each field value 0..4, upper bits of word 1 set
    idle(2);
    cfg_write(1'b1, 32'hFFF4_3210);
    observe("R5");

    // R6: saturating fields
    idle(7);
    cfg_write(1'b1, 32'h000F_9765);
    observe("R6");

    // R7: word 1 retained across word 0 write
    idle(1);
    cfg_write(1'b0, 32'h0000_0300);
    observe("R7");

    // R8: rewrite same value at an odd phase, restart realigns
    idle(11);
    cfg_write(1'b1, w1);
    observe("R8");

    // R2: extremes
    cfg_write(1'b0, 32'h0000_0000);
    cfg_write(1'b1, 32'h0000_0000);
    observe("R2");
    cfg_write(1'b0, 32'h0000_FFFF);
    cfg_write(1'b1, 32'h0000_F4F4);
    observe("R2");

    // R2: random mix
    for (int i = 0; i < 12; i++) begin
      idle($urandom_range(0, 9));
      if ($urandom_range(0, 1) == 1)
        cfg_write(1'b0, {$urandom_range(0, 65535) & 32'hFFFF, 8'($urandom_range(0, 7)), 8'($urandom_range(0, 7))});
      else
        cfg_write(1'b1, $urandom);
      observe("R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule